// File: doc/BRIEF.md
# Segmented Write Response Generator

This block sits behind the admission logic of a bus target. Once a write transfer has been accepted, it turns the transfer into a series of response descriptors for a response queue. It also packs the incoming payload bytes into 32-bit words for the receive FIFO. A long write is cut into chunks of a programmable byte count. Each chunk gets its own descriptor, and the descriptors carry first and last markers, so software can drain data while the transfer is still arriving.

When a transfer starts, the block can place one command word in the data stream ahead of the payload. The command-size field of the first descriptor tells the consumer how many bytes of that word are valid. This lets a CCC code, a defining byte or HDR bulk-transfer command bytes travel with the data.

The device-count broadcast CCC is a special case. It writes nothing to the FIFO and reports the count in the length field. A broadcast vendor CCC with a defining byte pushes that byte into the payload, because the consumer cannot tell it apart from data. Every output is registered and appears one clock after the input cycle that causes it. The threshold must be held steady from the start of a transfer until one cycle after its final descriptor.

Top module: `wr_resp_gen`

## Requirements
- R1: While reset is asserted, and right after it, `rxValid` and `respValid` are low.
- R2: Each time the payload byte count since the last descriptor reaches a non-zero `threshold`, a descriptor is written on the next cycle. It has length = `threshold`, LAST=0 and error 0, and FIRST=1 only for the first descriptor of the transfer.
- R3: The cycle after `xferEnd`, a descriptor with LAST=1 is written. Its length is the count of bytes since the previous descriptor (never above the threshold), and its error field is `errCode` from the end cycle.
- R4: Payload bytes are packed little-endian, first byte in bits [7:0]. A full word is written the cycle after its fourth byte. A partial word is written the cycle after `xferEnd`, with unused bytes zero.
- R5: A threshold of 0 means no chunking: only the end descriptor is produced, and it carries the whole byte count.
- R6: When the byte count is an exact multiple of the threshold, the end descriptor has length 0, FIRST=0 and LAST=1.
- R7: `startMode` selects the command word: 0 = none (size 0), 1 = code only (size 1), 2 = code plus defining byte, 3 = HDR bulk (size 4). A non-zero size writes the command word on the cycle after `xferStart`. The size field appears only in the FIRST descriptor and is 0 in all others.
- R8: Mode 2 with `startBcast`=0 gives size 2 and word {16'h0, defining byte `startCmdBytes[15:8]`, code `startCmdBytes[7:0]`}.
- R9: Mode 3 gives size 4 and the word `startCmdBytes` unmasked. Mode 1 gives {24'h0, code}.
- R10: Mode 2 with `startBcast`=1 gives size 1 (code only). The defining byte becomes the first payload byte, is counted in lengths, and can complete a chunk at start.
- R11: With `startDevCnt`=1, nothing reaches the FIFO, the size field is 0 and bit 30 is set. A single FIRST+LAST descriptor has as its length the first payload byte, or 0 if there was none.
- R12: Descriptor layout: length [15:0], target ID [19:16], size [22:20], CCC flag [23], error [27:24], FIRST [28], LAST [29], device-count [30], attribute [31] always 0.
- R13: Payload bytes and `xferEnd` outside a transfer cause no FIFO or queue write, and no output appears without a start, byte or end input in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| xferStart | input | 1 | Pulse: an accepted write transfer begins |
| startMode | input | 2 | Command word mode (0 none, 1 code, 2 code+defining byte, 3 bulk) |
| startBcast | input | 1 | Transfer is a broadcast CCC |
| startTid | input | 4 | Target ID for the descriptors |
| startCcc | input | 1 | Transfer is a vendor CCC rather than a private write |
| startDevCnt | input | 1 | Transfer is the device-count broadcast CCC |
| startCmdBytes | input | 32 | Code in byte 0, defining byte in byte 1, or four bulk bytes |
| byteValid | input | 1 | Payload byte strobe |
| byteData | input | 8 | Payload byte |
| xferEnd | input | 1 | Pulse: STOP or repeated START ends the transfer |
| errCode | input | 4 | Error status, sampled with `xferEnd` |
| threshold | input | 16 | Bytes per descriptor, 0 for unlimited |
| respValid | output | 1 | Descriptor write strobe |
| respData | output | 32 | Packed descriptor |
| rxValid | output | 1 | Receive FIFO word write strobe |
| rxWord | output | 32 | Receive FIFO word |

## Verification
A wrong chunk counter shows up within one cycle of the byte that should have closed a chunk: a descriptor is missing, comes a cycle late, or has a length other than the threshold. A lane pointer that is off by one puts payload bytes in the wrong position of the very next word, or gives a word write one byte early or late. A stale first marker or latched command size shows in the first two descriptors of the next transfer. A device-count transfer that leaks into the data path shows up as FIFO writes during its payload cycles. The reference model checks both strobes and both data buses on every clock, so each of these faults shows up in the cycle it happens.

// File: rtl/wrg_pkg.sv
package wrg_pkg;

  localparam int LEN_W      = 16;
  localparam int TID_W      = 4;
  localparam int ERR_W      = 4;
  localparam int CSZ_W      = 3;
  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;
  localparam int LANE_W     = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    MODE_NONE     = 2'd0,
    MODE_CODE     = 2'd1,
    MODE_CODE_DEF = 2'd2,
    MODE_BULK     = 2'd3
  } cmdMode_e;

  // packed MSB first: attr lands at bit 31, len at [15:0]
  typedef struct packed {
    logic              attr;
    logic              devCnt;
    logic              last;
    logic              first;
    logic [ERR_W-1:0]  err;
    logic              ccc;
    logic [CSZ_W-1:0]  cmdSize;
    logic [TID_W-1:0]  tid;
    logic [LEN_W-1:0]  len;
  } respFields_t;

  localparam int RESP_W = $bits(respFields_t);

  typedef struct packed {
    logic              clrAcc;
    logic              accEn;
    logic [BYTE_W-1:0] accByte;
    logic              cmdWr;
    logic [CSZ_W-1:0]  cmdSize;
    logic              flush;
    logic              respEn;
    respFields_t       resp;
  } ctrlStrobe_t;

  function automatic logic [CSZ_W-1:0] sizeOf(cmdMode_e m, logic bcast, logic dev);
    logic [CSZ_W-1:0] s;
    if (dev) s = '0;
    else begin
      unique case (m)
        MODE_NONE:     s = CSZ_W'(0);
        MODE_CODE:     s = CSZ_W'(1);
        MODE_CODE_DEF: s = bcast ? CSZ_W'(1) : CSZ_W'(2);
        default:       s = CSZ_W'(4);
      endcase
    end
    return s;
  endfunction

endpackage

// File: rtl/wrg_ctrl.sv
module wrg_ctrl
  import wrg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  cmdMode_e          startMode,
  input  logic              startBcast,
  input  logic [TID_W-1:0]  startTid,
  input  logic              startCcc,
  input  logic              startDevCnt,
  input  logic [BYTE_W-1:0] startDefByte,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              xferEnd,
  input  logic [ERR_W-1:0]  errCode,
  input  logic [LEN_W-1:0]  threshold,
  output ctrlStrobe_t       strb
);

  logic              activeQ, firstQ, devQ, devGotQ, cccQ;
  logic [TID_W-1:0]  tidQ;
  logic [CSZ_W-1:0]  sizeQ;
  logic [LEN_W-1:0]  chunkQ;
  logic [BYTE_W-1:0] devCountQ;

  logic [CSZ_W-1:0]  sizeNew, curSize;
  logic              inject, byteGo, devByte, endGo, addOne, firstBase, chunkHit, firstNext;
  logic              curCcc, curDev;
  logic [TID_W-1:0]  curTid;
  logic [LEN_W-1:0]  cntBase, cntInc, chunkNext;

  always_comb begin
    sizeNew   = sizeOf(startMode, startBcast, startDevCnt);
    inject    = !startDevCnt && (startMode == MODE_CODE_DEF) && startBcast;
    byteGo    = activeQ && byteValid && !xferStart && !xferEnd;
    devByte   = byteGo && devQ && !devGotQ;
    endGo     = activeQ && xferEnd && !xferStart;
    addOne    = xferStart ? inject : (byteGo && !devQ);
    cntBase   = xferStart ? '0 : chunkQ;
    firstBase = xferStart | firstQ;
    cntInc    = cntBase + LEN_W'(1);
    chunkHit  = addOne && (threshold != '0) && (cntInc == threshold);
    curSize   = xferStart ? sizeNew     : sizeQ;
    curTid    = xferStart ? startTid    : tidQ;
    curCcc    = xferStart ? startCcc    : cccQ;
    curDev    = xferStart ? startDevCnt : devQ;
    chunkNext = addOne ? cntInc : cntBase;
    firstNext = firstBase;

    strb         = '0;
    strb.clrAcc  = xferStart;
    strb.accEn   = addOne;
    strb.accByte = xferStart ? startDefByte : byteData;
    strb.cmdWr   = xferStart && (sizeNew != '0);
    strb.cmdSize = sizeNew;

    if (chunkHit) begin
      strb.respEn     = 1'b1;
      strb.resp.len   = threshold;
      strb.resp.first = firstBase;
      chunkNext       = '0;
      firstNext       = 1'b0;
    end
    if (endGo) begin
      strb.respEn     = 1'b1;
      strb.resp.len   = devQ ? LEN_W'(devCountQ) : chunkQ;
      strb.resp.first = firstQ;
      strb.resp.last  = 1'b1;
      strb.resp.err   = errCode;
      strb.flush      = !devQ;
    end
    strb.resp.tid     = curTid;
    strb.resp.ccc     = curCcc;
    strb.resp.devCnt  = curDev;
    strb.resp.cmdSize = strb.resp.first ? curSize : '0;
    strb.resp.attr    = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ   <= 1'b0;
      firstQ    <= 1'b0;
      devQ      <= 1'b0;
      devGotQ   <= 1'b0;
      cccQ      <= 1'b0;
      tidQ      <= '0;
      sizeQ     <= '0;
      chunkQ    <= '0;
      devCountQ <= '0;
    end else begin
      chunkQ <= chunkNext;
      firstQ <= firstNext;
      if (xferStart) begin
        activeQ   <= 1'b1;
        devQ      <= startDevCnt;
        cccQ      <= startCcc;
        tidQ      <= startTid;
        sizeQ     <= sizeNew;
        devGotQ   <= 1'b0;
        devCountQ <= '0;
      end else if (endGo) begin
        activeQ <= 1'b0;
      end
      if (devByte) begin
        devCountQ <= byteData;
        devGotQ   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/wrg_dp.sv
module wrg_dp
  import wrg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strb,
  input  logic [WORD_W-1:0] cmdBytes,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxWord,
  output logic              respValid,
  output logic [RESP_W-1:0] respData
);

  logic [WORD_W-1:0] accQ, accBase, accUpd, cmdMasked;
  logic [LANE_W-1:0] cntQ, cntBase;
  logic              wordDone, flushGo;

  always_comb begin
    accBase  = strb.clrAcc ? '0 : accQ;
    cntBase  = strb.clrAcc ? '0 : cntQ;
    wordDone = strb.accEn && (cntBase == LANE_W'(WORD_BYTES - 1));
    flushGo  = strb.flush && (cntQ != '0);
  end

  for (genvar l = 0; l < WORD_BYTES; l++) begin : g_lane
    assign accUpd[l*BYTE_W +: BYTE_W] =
      (strb.accEn && (cntBase == LANE_W'(l))) ? strb.accByte : accBase[l*BYTE_W +: BYTE_W];
    assign cmdMasked[l*BYTE_W +: BYTE_W] =
      (int'(strb.cmdSize) > l) ? cmdBytes[l*BYTE_W +: BYTE_W] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ      <= '0;
      cntQ      <= '0;
      rxValid   <= 1'b0;
      rxWord    <= '0;
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      rxValid <= strb.cmdWr | wordDone | flushGo;
      if (strb.cmdWr)   rxWord <= cmdMasked;
      else if (wordDone) rxWord <= accUpd;
      else if (flushGo)  rxWord <= accQ;

      if (wordDone || strb.flush) begin
        accQ <= '0;
        cntQ <= '0;
      end else if (strb.accEn) begin
        accQ <= accUpd;
        cntQ <= cntBase + LANE_W'(1);
      end else if (strb.clrAcc) begin
        accQ <= '0;
        cntQ <= '0;
      end

      respValid <= strb.respEn;
      if (strb.respEn) respData <= strb.resp;
    end
  end

endmodule

// File: rtl/wr_resp_gen.sv
module wr_resp_gen
  import wrg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              xferStart,
  input  logic [1:0]        startMode,
  input  logic              startBcast,
  input  logic [TID_W-1:0]  startTid,
  input  logic              startCcc,
  input  logic              startDevCnt,
  input  logic [WORD_W-1:0] startCmdBytes,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              xferEnd,
  input  logic [ERR_W-1:0]  errCode,
  input  logic [LEN_W-1:0]  threshold,
  output logic              respValid,
  output logic [RESP_W-1:0] respData,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxWord
);

  ctrlStrobe_t strb;

  wrg_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .xferStart   (xferStart),
    .startMode   (cmdMode_e'(startMode)),
    .startBcast  (startBcast),
    .startTid    (startTid),
    .startCcc    (startCcc),
    .startDevCnt (startDevCnt),
    .startDefByte(startCmdBytes[2*BYTE_W-1:BYTE_W]),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .xferEnd     (xferEnd),
    .errCode     (errCode),
    .threshold   (threshold),
    .strb        (strb)
  );

  wrg_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cmdBytes (startCmdBytes),
    .rxValid  (rxValid),
    .rxWord   (rxWord),
    .respValid(respValid),
    .respData (respData)
  );

endmodule

// File: rtl/wrg_chk.sv
module wrg_chk (
  input logic        clk,
  input logic        rstN,
  input logic        xferStart,
  input logic        byteValid,
  input logic        xferEnd,
  input logic [15:0] threshold,
  input logic        respValid,
  input logic [31:0] respData,
  input logic        rxValid
);

  logic anyInQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) anyInQ <= 1'b0;
    else       anyInQ <= xferStart | byteValid | xferEnd;
  end

  // R13
  idle_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    !anyInQ |-> (!rxValid && !respValid));

  // R12
  attr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !respData[31]);

  // R7
  size_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respData[28]) |-> (respData[22:20] == 3'd0));

  // R7
  size_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> (respData[22:20] inside {3'd0, 3'd1, 3'd2, 3'd4}));

  // R11
  devcnt_size_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respData[30]) |-> (respData[22:20] == 3'd0));

  // R2
  mid_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respData[29] && threshold != 16'd0) |-> (respData[15:0] == threshold));

  // R3
  last_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respData[29] && !respData[30] && threshold != 16'd0) |-> (respData[15:0] <= threshold));

endmodule

bind wr_resp_gen wrg_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .xferStart(xferStart),
  .byteValid(byteValid),
  .xferEnd  (xferEnd),
  .threshold(threshold),
  .respValid(respValid),
  .respData (respData),
  .rxValid  (rxValid)
);

// File: tb/sim_wr_resp_gen.sv
`timescale 1ns/1ps
module sim_wr_resp_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        xferStart = 1'b0;
  logic [1:0]  startMode = 2'd0;
  logic        startBcast = 1'b0;
  logic [3:0]  startTid = 4'd0;
  logic        startCcc = 1'b0;
  logic        startDevCnt = 1'b0;
  logic [31:0] startCmdBytes = 32'd0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = 8'd0;
  logic        xferEnd = 1'b0;
  logic [3:0]  errCode = 4'd0;
  logic [15:0] threshold = 16'd0;
  logic        respValid;
  logic [31:0] respData;
  logic        rxValid;
  logic [31:0] rxWord;

  always #2.5 clk = ~clk;

  wr_resp_gen u0 (.*);

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 0;
  string curReq = "R1";

  // reference model state
  bit          mAct, mFirst, mDev, mDevGot, mCcc;
  int          mCnt;
  int          mSize;
  logic [3:0]  mTid;
  logic [7:0]  mDevCount;
  logic [7:0]  mq[$];
  logic        expRV, expXV;
  logic [31:0] expRD, expXW;

  function automatic logic [31:0] mkResp(int len, bit first, bit last, logic [3:0] err);
    logic [2:0] sz;
    sz = first ? 3'(mSize) : 3'd0;
    return {1'b0, mDev, last, first, err, mCcc, sz, mTid, 16'(len)};
  endfunction

  task automatic addByte(logic [7:0] b);
    mq.push_back(b);
    if (mq.size() == 4) begin
      expXV = 1'b1;
      expXW = {mq[3], mq[2], mq[1], mq[0]};
      mq.delete();
    end
    mCnt++;
    if (threshold != 0 && mCnt == int'(threshold)) begin
      expRV  = 1'b1;
      expRD  = mkResp(mCnt, mFirst, 1'b0, 4'd0);
      mFirst = 1'b0;
      mCnt   = 0;
    end
  endtask

  task automatic model();
    expRV = 1'b0;
    expXV = 1'b0;
    if (xferStart) begin
      mAct = 1; mFirst = 1; mCnt = 0; mTid = startTid; mCcc = startCcc;
      mDev = startDevCnt; mDevGot = 0; mDevCount = 8'd0; mq.delete();
      if (startDevCnt) mSize = 0;
      else case (startMode)
        2'd0: mSize = 0;
        2'd1: mSize = 1;
        2'd2: mSize = startBcast ? 1 : 2;
        default: mSize = 4;
      endcase
      if (mSize == 1) begin expXV = 1; expXW = {24'd0, startCmdBytes[7:0]}; end
      if (mSize == 2) begin expXV = 1; expXW = {16'd0, startCmdBytes[15:0]}; end
      if (mSize == 4) begin expXV = 1; expXW = startCmdBytes; end
      if (!startDevCnt && startMode == 2'd2 && startBcast) addByte(startCmdBytes[15:8]);
    end else if (mAct && xferEnd) begin
      expRV = 1;
      expRD = mkResp(mDev ? int'(mDevCount) : mCnt, mFirst, 1'b1, errCode);
      if (!mDev && mq.size() > 0) begin
        expXV = 1;
        expXW = 32'd0;
        foreach (mq[i]) expXW[i*8 +: 8] = mq[i];
        mq.delete();
      end
      mAct = 0;
    end else if (mAct && byteValid) begin
      if (mDev) begin
        if (!mDevGot) begin mDevCount = byteData; mDevGot = 1; end
      end else addByte(byteData);
    end
  endtask

  task automatic compare();
    nCmp++;
    if (rxValid !== expXV || (expXV && rxWord !== expXW) ||
        respValid !== expRV || (expRV && respData !== expRD)) begin
      nBad++;
      $display("FAIL %s t=%0t rx=%b/%h exp %b/%h resp=%b/%h exp %b/%h", curReq, $time,
               rxValid, rxWord, expXV, expXW, respValid, respData, expRV, expRD);
    end
  endtask

  task automatic step();
    model();
    @(negedge clk);
    compare();
    xferStart = 0; byteValid = 0; xferEnd = 0;
  endtask

  task automatic doStart(logic [1:0] m, logic bc, logic [3:0] t, logic c, logic d, logic [31:0] cb);
    xferStart = 1; startMode = m; startBcast = bc; startTid = t;
    startCcc = c; startDevCnt = d; startCmdBytes = cb;
    step();
  endtask

  task automatic doBytes(int n, logic [7:0] base, int gap);
    for (int i = 0; i < n; i++) begin
      byteValid = 1; byteData = base + 8'(i);
      step();
      for (int g = 0; g < gap; g++) step();
    end
  endtask

  task automatic doEnd(logic [3:0] e);
    xferEnd = 1; errCode = e;
    step();
    step(); step();
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      report();
    end
  end

  initial begin
    expRV = 0; expXV = 0; expRD = 0; expXW = 0;
    mAct = 0; mFirst = 0; mDev = 0; mDevGot = 0; mCcc = 0; mCnt = 0; mSize = 0;
    mTid = 0; mDevCount = 0;
    // R1: quiet during and after reset
    curReq = "R1";
    for (int i = 0; i < 3; i++) begin @(negedge clk); compare(); end
    rstN = 1;
    step(); step();

    // R2 / R4: 10 bytes, threshold 4
    curReq = "R2/R4"; threshold = 16'd4;
    doStart(2'd0, 0, 4'd3, 0, 0, 32'h0);
    doBytes(10, 8'h10, 0);
    doEnd(4'd0);

    // R5: unlimited threshold with gaps between bytes
    curReq = "R5"; threshold = 16'd0;
    doStart(2'd0, 0, 4'd5, 0, 0, 32'h0);
    doBytes(9, 8'h40, 1);
    doEnd(4'd0);

    // R6: exact multiple of threshold
    curReq = "R6"; threshold = 16'd4;
    doStart(2'd0, 0, 4'd1, 0, 0, 32'h0);
    doBytes(8, 8'h80, 0);
    doEnd(4'd0);

    // R3 / R12: remainder plus error code
    curReq = "R3/R12"; threshold = 16'd5;
    doStart(2'd0, 0, 4'd9, 0, 0, 32'h0);
    doBytes(7, 8'hA0, 0);
    doEnd(4'hA);

    // R7: code-only command word
    curReq = "R7"; threshold = 16'd3;
    doStart(2'd1, 0, 4'd2, 1, 0, 32'h1234_569A);
    doBytes(5, 8'h01, 0);
    doEnd(4'd0);

    // R8: directed CCC with defining byte
    curReq = "R8"; threshold = 16'd2;
    doStart(2'd2, 0, 4'd7, 1, 0, 32'hABCD_5566);
    doBytes(3, 8'hC0, 0);
    doEnd(4'd0);

    // R9: HDR bulk command bytes
    curReq = "R9"; threshold = 16'd6;
    doStart(2'd3, 0, 4'd4, 0, 0, 32'hDEAD_BEEF);
    doBytes(6, 8'h21, 0);
    doEnd(4'd3);

    // R10: broadcast CCC, defining byte becomes payload, threshold 1
    curReq = "R10"; threshold = 16'd1;
    doStart(2'd2, 1, 4'd15, 1, 0, 32'h0000_7731);
    doBytes(2, 8'h50, 0);
    doEnd(4'd0);

    // R10 with larger threshold so the injected byte shares a word
    curReq = "R10"; threshold = 16'd4;
    doStart(2'd2, 1, 4'd6, 1, 0, 32'h0000_E2F1);
    doBytes(5, 8'h60, 0);
    doEnd(4'd0);

    // R11: device-count broadcast
    curReq = "R11"; threshold = 16'd2;
    doStart(2'd2, 1, 4'd8, 1, 1, 32'h0000_1122);
    doBytes(3, 8'h07, 0);
    doEnd(4'd0);

    // R13: bytes and end outside a transfer
    curReq = "R13";
    doBytes(3, 8'h99, 0);
    xferEnd = 1; errCode = 4'hF; step();
    step(); step();

    // R2 again after idle traffic: fresh FIRST flag
    curReq = "R2"; threshold = 16'd3;
    doStart(2'd0, 0, 4'd11, 0, 0, 32'h0);
    doBytes(4, 8'h33, 0);
    doEnd(4'd0);

    done = 1;
    report();
  end

endmodule